// File: doc/BRIEF.md
# DMA Trigger Condition Unit

This unit sits beside one DMA channel and decides when that channel may take its next step. It watches a bus of hardware event lines and picks one line by a numeric index. Each line is first brought into the clock domain by a two-flop synchroniser, and its edges are then detected. A two-bit polarity setting chooses rising edges, falling edges, or no trigger at all. A detected edge is called a hit.

A hit does not start a whole transfer. It releases the channel at one of four granularities that a trigger mode selects: one block, one repeated-block sequence, one linked-list item load, or one single/burst transfer. The channel reports the start and the end of each kind of step on two four-bit strobe vectors. The unit raises `go_o` while a hit is pending and the gated step is idle.

The unit holds at most one pending hit. A start of the gated step consumes it. A hit that arrives while one is already pending and is not being consumed gives a one-cycle overrun pulse.

Top module: `dma_trig_gate`

## Requirements
- R1: After reset `go_o` and `ovr_o` are 0 and no step is in progress.
- R2: With polarity code 1, a rising edge on the selected event produces a hit, and `go_o` is high after the third rising clock edge that follows the input change.
- R3: With polarity code 2, a falling edge on the selected event produces a hit, with the same latency as R2.
- R4: Polarity code 0 masks the trigger and never releases the channel. Reserved code 3 behaves the same way.
- R5: An index at or above `NUM_VALID` (default 46) sets `sel_err_o`, and no edge on that line ever produces a hit.
- R6: Trigger mode m gates the step reported on bit m of `step_start_i` and `step_done_i`. The bits are: 0 block, 1 repeated block, 2 linked-list item load, 3 single/burst. Strobes on the other bits have no effect on `go_o`.
- R7: A start strobe of the gated step consumes the pending hit. `go_o` is low from the following cycle until the matching done strobe.
- R8: Hits never accumulate beyond one pending hit. A hit that arrives while one is pending raises `ovr_o` for exactly one cycle, in the same cycle where a first hit would raise `go_o`.
- R9: When a hit and the gated start strobe fall in the same cycle, the old hit is consumed and the new hit stays pending, with no overrun.
- R10: A hit that arrives while the gated step is in progress is kept. `go_o` rises in the cycle after the done strobe.
- R11: Edges on lines that are not selected produce no hit. Switching the index to a line that is already high produces no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_EVT | Hardware event lines, asynchronous |
| cfg_sel_i | input | SEL_W | Index of the event line to watch |
| cfg_pol_i | input | 2 | 0 masked, 1 rising, 2 falling, 3 masked |
| cfg_mode_i | input | 2 | Granularity of the step that is gated |
| step_start_i | input | 4 | Start strobe per step kind |
| step_done_i | input | 4 | Done strobe per step kind |
| go_o | output | 1 | Channel may start the gated step |
| ovr_o | output | 1 | One-cycle pulse when a hit is lost |
| sel_err_o | output | 1 | Selected index is out of range |

## Verification
Two functions can fall in the same cycle: consuming a pending hit on a gated start, and latching a fresh hit. The bench provokes this by changing the event line and then asserting the start strobe on the falling clock edge just before the edge at which the new hit is registered. The result is judged at the ports. `ovr_o` must stay low in that cycle, `go_o` must stay low while the step runs, and `go_o` must rise after the done strobe, which shows that the new hit survived.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;

   typedef enum logic [1:0] {
      POL_OFF  = 2'd0,
      POL_RISE = 2'd1,
      POL_FALL = 2'd2,
      POL_RSVD = 2'd3
   } trig_pol_e;

   // The code value is also the bit position on the step strobe vectors.
   typedef enum logic [1:0] {
      GRAN_BLOCK  = 2'd0,
      GRAN_REPEAT = 2'd1,
      GRAN_LINK   = 2'd2,
      GRAN_BEAT   = 2'd3
   } trig_gran_e;

   localparam int unsigned GRAN_COUNT = 4;

endpackage

// File: rtl/dma_trig_sync_edge.sv
// Synchronises every event line and reports its rising and falling edges.
module dma_trig_sync_edge #(
   parameter int unsigned NUM_EVT = 64,
   parameter int unsigned STAGES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic [NUM_EVT-1:0] rise_o,
   output logic [NUM_EVT-1:0] fall_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("dma_trig_sync_edge: STAGES must be at least 2");
   end

   logic [NUM_EVT-1:0] stg_q [STAGES];
   logic [NUM_EVT-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
         prev_q <= '0;
      end else begin
         stg_q[0] <= evt_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
         prev_q <= stg_q[LAST];
      end
   end

   // Edges are kept per line, so changing the index cannot create a false edge.
   for (genvar e = 0; e < NUM_EVT; e++) begin : g_edge
      assign rise_o[e] =  stg_q[LAST][e] & ~prev_q[e];
      assign fall_o[e] = ~stg_q[LAST][e] &  prev_q[e];
   end

endmodule

// File: rtl/dma_trig_select.sv
// Picks one line by index and applies the polarity setting.
module dma_trig_select
   import dma_trig_pkg::*;
#(
   parameter int unsigned NUM_EVT   = 64,
   parameter int unsigned NUM_VALID = 46,
   parameter int unsigned SEL_W     = $clog2(NUM_EVT)
) (
   input  logic [NUM_EVT-1:0] rise_i,
   input  logic [NUM_EVT-1:0] fall_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [1:0]         pol_i,
   output logic               hit_o,
   output logic               sel_err_o
);
   trig_pol_e pol;
   logic      rise_sel, fall_sel;

   assign pol       = trig_pol_e'(pol_i);
   assign sel_err_o = (32'(sel_i) >= NUM_VALID);
   assign rise_sel  = rise_i[sel_i];
   assign fall_sel  = fall_i[sel_i];

   always_comb begin
      hit_o = 1'b0;
      if (!sel_err_o) begin
         unique case (pol)
            POL_RISE: hit_o = rise_sel;
            POL_FALL: hit_o = fall_sel;
            default:  hit_o = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/dma_trig_pend.sv
// Holds one pending hit and tracks whether the gated step is running.
module dma_trig_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic start_i,
   input  logic done_i,
   output logic pend_o,
   output logic busy_o,
   output logic ovr_o
);
   logic pend_q, busy_q, ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         busy_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         pend_q <= hit_i | (pend_q & ~start_i);
         busy_q <= start_i | (busy_q & ~done_i);
         ovr_q  <= hit_i & pend_q & ~start_i;
      end
   end

   assign pend_o = pend_q;
   assign busy_o = busy_q;
   assign ovr_o  = ovr_q;

endmodule

// File: rtl/dma_trig_gate.sv
module dma_trig_gate
   import dma_trig_pkg::*;
#(
   parameter int unsigned NUM_EVT   = 64,
   parameter int unsigned NUM_VALID = 46,
   parameter int unsigned STAGES    = 2,
   parameter int unsigned SEL_W     = $clog2(NUM_EVT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [SEL_W-1:0]   cfg_sel_i,
   input  logic [1:0]         cfg_pol_i,
   input  logic [1:0]         cfg_mode_i,
   input  logic [3:0]         step_start_i,
   input  logic [3:0]         step_done_i,
   output logic               go_o,
   output logic               ovr_o,
   output logic               sel_err_o
);
   if (NUM_VALID == 0 || NUM_VALID > NUM_EVT) begin : g_bad_valid
      $error("dma_trig_gate: NUM_VALID must lie in 1..NUM_EVT");
   end
   if ((1 << SEL_W) < NUM_EVT) begin : g_bad_selw
      $error("dma_trig_gate: SEL_W too narrow for NUM_EVT");
   end

   logic [NUM_EVT-1:0] rise, fall;
   logic               hit;
   logic               start_sel, done_sel;
   logic               pend_q, busy_q;

   dma_trig_sync_edge #(.NUM_EVT(NUM_EVT), .STAGES(STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i),
      .rise_o (rise),
      .fall_o (fall)
   );

   dma_trig_select #(.NUM_EVT(NUM_EVT), .NUM_VALID(NUM_VALID), .SEL_W(SEL_W)) u_sel (
      .rise_i    (rise),
      .fall_i    (fall),
      .sel_i     (cfg_sel_i),
      .pol_i     (cfg_pol_i),
      .hit_o     (hit),
      .sel_err_o (sel_err_o)
   );

   assign start_sel = step_start_i[cfg_mode_i];
   assign done_sel  = step_done_i[cfg_mode_i];

   dma_trig_pend u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit),
      .start_i (start_sel),
      .done_i  (done_sel),
      .pend_o  (pend_q),
      .busy_o  (busy_q),
      .ovr_o   (ovr_o)
   );

   assign go_o = pend_q & ~busy_q;

endmodule

// File: rtl/dma_trig_gate_chk.sv
module dma_trig_gate_chk #(
   parameter int unsigned SEL_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cfg_pol_i,
   input logic [1:0]       cfg_mode_i,
   input logic [3:0]       step_start_i,
   input logic             sel_err_o,
   input logic             hit,
   input logic             pend_q,
   input logic             go_o,
   input logic             ovr_o
);
   logic gstart;
   assign gstart = step_start_i[cfg_mode_i];

   p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pol_i == 2'd0 || cfg_pol_i == 2'd3) |=> !$rose(pend_q));

   p_badsel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sel_err_o |=> !$rose(pend_q));

   p_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (gstart && !hit) |=> !pend_q);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      gstart |=> !go_o);

   p_ovr_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_o |-> pend_q);

   p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (gstart && hit) |=> (pend_q && !ovr_o));

endmodule

bind dma_trig_gate dma_trig_gate_chk #(.SEL_W(SEL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_pol_i    (cfg_pol_i),
   .cfg_mode_i   (cfg_mode_i),
   .step_start_i (step_start_i),
   .sel_err_o    (sel_err_o),
   .hit          (hit),
   .pend_q       (pend_q),
   .go_o         (go_o),
   .ovr_o        (ovr_o)
);

// File: tb/dma_trig_gate_tb.sv
`timescale 1ns/1ps
module dma_trig_gate_tb_top;
   localparam int NEVT = 64;
   localparam int NVAL = 46;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NEVT-1:0] evt = '0;
   logic [5:0]      sel = '0;
   logic [1:0]      pol = '0;
   logic [1:0]      mode = '0;
   logic [3:0]      sst = '0;
   logic [3:0]      sdn = '0;
   logic            go, ovr, serr;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   always #2 clk = ~clk;

   dma_trig_gate dut_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .cfg_sel_i(sel), .cfg_pol_i(pol),
      .cfg_mode_i(mode), .step_start_i(sst), .step_done_i(sdn),
      .go_o(go), .ovr_o(ovr), .sel_err_o(serr));

   // Row layout: [10:9] polarity, [8:3] index, [2:1] mode, [0] expected go
   localparam logic [10:0] ROWS [8] = '{
      {2'd1, 6'd3,  2'd0, 1'b1},
      {2'd2, 6'd45, 2'd3, 1'b1},
      {2'd0, 6'd10, 2'd1, 1'b0},
      {2'd3, 6'd7,  2'd2, 1'b0},
      {2'd1, 6'd46, 2'd0, 1'b0},
      {2'd2, 6'd63, 2'd1, 1'b0},
      {2'd1, 6'd0,  2'd2, 1'b1},
      {2'd2, 6'd20, 2'd3, 1'b1}
   };

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the falling edge after the hit is registered.
   task automatic settle();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic start_pulse(input int m);
      sst = 4'(1 << m);
      @(negedge clk);
      sst = '0;
   endtask

   task automatic done_pulse(input int m);
      sdn = 4'(1 << m);
      @(negedge clk);
      sdn = '0;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 go after reset", go, 1'b0);
      check("R1 ovr after reset", ovr, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R2, R3, R4, R5
      for (int i = 0; i < 8; i++) begin
         pol  = ROWS[i][10:9];
         sel  = ROWS[i][8:3];
         mode = ROWS[i][2:1];
         @(negedge clk);
         evt[sel] = 1'b1;
         settle();
         evt[sel] = 1'b0;
         settle();
         check(pol == 2'd1 ? "R2 rising row" : pol == 2'd2 ? "R3 falling row"
               : "R4 masked row", go, ROWS[i][0]);
         check("R5 index range flag", serr, (int'(sel) >= NVAL));
         start_pulse(int'(mode));
         done_pulse(int'(mode));
         check("R7 cleared after row", go, 1'b0);
      end

      // R2 latency: go must still be low two edges after the change
      pol = 2'd1; sel = 6'd2; mode = 2'd0;
      @(negedge clk);
      evt[2] = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R2 not yet at second edge", go, 1'b0);
      @(negedge clk);
      check("R2 at third edge", go, 1'b1);
      start_pulse(1);
      check("R6 unselected start ignored", go, 1'b1);
      start_pulse(0);
      check("R7 consumed by start", go, 1'b0);
      evt[2] = 1'b0; settle();
      evt[2] = 1'b1; settle();
      check("R10 held while busy", go, 1'b0);
      done_pulse(1);
      check("R6 unselected done ignored", go, 1'b0);
      done_pulse(0);
      check("R10 released after done", go, 1'b1);
      start_pulse(0); done_pulse(0);
      evt[2] = 1'b0; settle();

      // R9: hit and gated start in the same cycle
      evt[2] = 1'b1; settle();
      check("R9 setup pending", go, 1'b1);
      evt[2] = 1'b0; settle();
      evt[2] = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      sst = 4'b0001;
      @(negedge clk);
      sst = '0;
      check("R9 no overrun on collision", ovr, 1'b0);
      check("R9 busy after start", go, 1'b0);
      done_pulse(0);
      check("R9 new hit kept", go, 1'b1);
      start_pulse(0); done_pulse(0);
      evt[2] = 1'b0; settle();

      // R8: overrun and no accumulation
      evt[2] = 1'b1; settle();
      check("R8 first hit", ovr, 1'b0);
      evt[2] = 1'b0; settle();
      evt[2] = 1'b1; settle();
      check("R8 overrun pulse", ovr, 1'b1);
      @(negedge clk);
      check("R8 overrun one cycle", ovr, 1'b0);
      start_pulse(0); done_pulse(0);
      check("R8 no second hit stored", go, 1'b0);
      evt[2] = 1'b0; settle();

      // R11: other lines and index switch
      evt[5] = 1'b1; settle();
      check("R11 unselected edge", go, 1'b0);
      evt[9] = 1'b1; settle();
      sel = 6'd9;
      repeat (4) @(negedge clk);
      check("R11 switch to high line", go, 1'b0);
      evt[9] = 1'b0; evt[5] = 1'b0; settle();
      check("R11 falling not a hit on rising", go, 1'b0);

      finish_run();
   end
endmodule